// File: doc/BRIEF.md
# Complementary-Pair Word Error Corrector

This block protects a data word kept in dynamic storage cells that can only lose charge, so each cell can only flip one way. Every data bit is stored twice, once as itself in a true array and once inverted in a complement array, and one parity bit is stored with the word. Because a cell can only flip one way, an upset can corrupt at most one cell of a pair, and that pair then reads back as two equal values instead of two opposite ones. This locates the failing bit. The stored parity then tells the block which value that bit must take.

The write side is combinational. From a data word it produces the true image, the complement image and the parity bit. The read side takes both arrays and the parity bit, compares each pair, and classifies the word. The result goes into a verdict register with one cycle of latency. The verdict register has three states:
- CLEAN: no pair disagrees.
- FIXED: exactly one pair disagrees and the bit was repaired.
- FATAL: two or more pairs disagree.

In each cycle the next state is chosen from the flag count alone: zero flags goes to CLEAN, one flag goes to FIXED, and more than one goes to FATAL. Reset puts the register in CLEAN and clears the output data.

Top module: `cpc_corrector`

## Requirements
- R1: The write side drives `wr_true` equal to `wr_data` and `wr_comp` equal to the bitwise inverse of `wr_data`, combinationally.
- R2: `wr_par` is the XOR of all bits of `wr_data`, so data plus parity holds an even number of ones.
- R3: When every pair `rd_true[i]`/`rd_comp[i]` differs, the next cycle shows `q_data` = `rd_true`, with `q_corrected` = 0 and `q_uncorrectable` = 0 (CLEAN).
- R4: When exactly one pair k has equal values, the next cycle shows `q_data` equal to `rd_true` except bit k. Bit k takes the value that makes the XOR of `q_data` equal `rd_par`. The flags are `q_corrected` = 1 and `q_uncorrectable` = 0 (FIXED). This restores the written word for an upset in either half.
- R5: When two or more pairs have equal values, the next cycle shows `q_uncorrectable` = 1, `q_corrected` = 0 and `q_data` = `rd_true` (FATAL).
- R6: The outputs are registered with one cycle of latency. While `rst_n` is low, `q_data` = 0 and both flags are 0.
- R7: A flipped parity bit with all pairs complementary raises no flag and does not change `q_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | W | Word to be stored |
| wr_true | output | W | True-array image of the word |
| wr_comp | output | W | Complement-array image of the word |
| wr_par | output | 1 | Even parity of the word |
| rd_true | input | W | True array as read back |
| rd_comp | input | W | Complement array as read back |
| rd_par | input | 1 | Parity bit as read back |
| q_data | output | W | Corrected word, registered |
| q_corrected | output | 1 | A single bit was repaired |
| q_uncorrectable | output | 1 | More than one pair disagreed |

## Verification
The bench walks a table of words. For each word it injects a one-way flip at every bit position, in whichever half holds the charged cell, so both halves are covered across the table. A corrector that trusted one half, or that got the parity sense backwards, would return the wrong bit in these cases. Double flips check that the block does not "repair" a word with two bad pairs, which would set a wrong bit and still report success. The bench also checks that a lone parity flip does not cause a false repair, that the result appears only one cycle after its inputs, and the reset values.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
    typedef enum logic [1:0] {
        VERDICT_CLEAN = 2'd0,
        VERDICT_FIXED = 2'd1,
        VERDICT_FATAL = 2'd2
    } verdict_t;
endpackage

// File: rtl/cpc_encoder.sv
module cpc_encoder #(
    parameter int W = 16
) (
    input  logic [W-1:0] data_i,
    output logic [W-1:0] true_o,
    output logic [W-1:0] comp_o,
    output logic         par_o
);
    always_comb begin
        true_o = data_i;
        comp_o = ~data_i;
        par_o  = ^data_i;
    end
endmodule

// File: rtl/cpc_pair_check.sv
module cpc_pair_check #(
    parameter int W = 16
) (
    input  logic [W-1:0] true_i,
    input  logic [W-1:0] comp_i,
    output logic [W-1:0] flag_o
);
    // A healthy pair reads as opposite values; equal values mark the upset bit.
    for (genvar i = 0; i < W; i++) begin : g_pair
        assign flag_o[i] = ~(true_i[i] ^ comp_i[i]);
    end
endmodule

// File: rtl/cpc_resolver.sv
module cpc_resolver
    import cpc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] true_i,
    input  logic [W-1:0] flag_i,
    input  logic         par_i,
    output logic [W-1:0] data_o,
    output verdict_t     verdict_o
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] flag_cnt;
    logic [W-1:0]  kept;
    logic          fix_bit;

    always_comb begin
        flag_cnt = '0;
        for (int i = 0; i < W; i++) begin
            flag_cnt = flag_cnt + CW'(flag_i[i]);
        end
    end

    always_comb begin
        kept    = true_i & ~flag_i;
        fix_bit = par_i ^ (^kept);
        if (flag_cnt == CW'(0)) begin
            verdict_o = VERDICT_CLEAN;
            data_o    = true_i;
        end else if (flag_cnt == CW'(1)) begin
            verdict_o = VERDICT_FIXED;
            data_o    = kept | (flag_i & {W{fix_bit}});
        end else begin
            verdict_o = VERDICT_FATAL;
            data_o    = true_i;
        end
    end

    // r4: a repair touches only the flagged position
    always_comb begin
        if (verdict_o == VERDICT_FIXED) begin
            a_fix_only_flagged_r4: assert (((data_o ^ true_i) & ~flag_i) == '0);
        end
    end
endmodule

// File: rtl/cpc_corrector.sv
module cpc_corrector
    import cpc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] wr_true,
    output logic [W-1:0] wr_comp,
    output logic         wr_par,
    input  logic [W-1:0] rd_true,
    input  logic [W-1:0] rd_comp,
    input  logic         rd_par,
    output logic [W-1:0] q_data,
    output logic         q_corrected,
    output logic         q_uncorrectable
);
    logic [W-1:0] flags;
    logic [W-1:0] fixed_data;
    verdict_t     next_verdict;
    verdict_t     state;

    cpc_encoder #(.W(W)) u_enc (
        .data_i (wr_data),
        .true_o (wr_true),
        .comp_o (wr_comp),
        .par_o  (wr_par)
    );

    cpc_pair_check #(.W(W)) u_pairs (
        .true_i (rd_true),
        .comp_i (rd_comp),
        .flag_o (flags)
    );

    cpc_resolver #(.W(W)) u_res (
        .true_i    (rd_true),
        .flag_i    (flags),
        .par_i     (rd_par),
        .data_o    (fixed_data),
        .verdict_o (next_verdict)
    );

    // State register: verdict and data of the previous read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= VERDICT_CLEAN;
            q_data <= '0;
        end else begin
            state  <= next_verdict;
            q_data <= fixed_data;
        end
    end

    // Output decode
    always_comb begin
        q_corrected     = 1'b0;
        q_uncorrectable = 1'b0;
        unique case (state)
            VERDICT_CLEAN: ;
            VERDICT_FIXED: q_corrected = 1'b1;
            VERDICT_FATAL: q_uncorrectable = 1'b1;
            default:       q_uncorrectable = 1'b1;
        endcase
    end

    p_fix_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q_corrected |-> ((^q_data) == $past(rd_par)));

    p_fatal_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q_uncorrectable |-> (q_data == $past(rd_true)));

    p_clean_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_corrected && !q_uncorrectable) |-> (q_data == $past(rd_true)));

    p_flag_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_corrected && q_uncorrectable));
endmodule

// File: tb/cpc_corrector_bench.sv
module cpc_corrector_bench;
    localparam int W = 16;
    localparam int NV = 6;
    localparam logic [W-1:0] VEC [NV] = '{16'h0000, 16'hFFFF, 16'hA5C3,
                                          16'h0001, 16'h8000, 16'h1234};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] wr_true, wr_comp;
    logic         wr_par;
    logic [W-1:0] rd_true = '0;
    logic [W-1:0] rd_comp = '1;
    logic         rd_par = 1'b0;
    logic [W-1:0] q_data;
    logic         q_corrected, q_uncorrectable;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cpc_corrector #(.W(W)) u_cpc_corrector (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
        .wr_true(wr_true), .wr_comp(wr_comp), .wr_par(wr_par),
        .rd_true(rd_true), .rd_comp(rd_comp), .rd_par(rd_par),
        .q_data(q_data), .q_corrected(q_corrected),
        .q_uncorrectable(q_uncorrectable)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply read inputs, wait one edge, then compare.
    task automatic rd_check(input logic [W-1:0] t, input logic [W-1:0] c,
                            input logic p, input logic [W-1:0] exp_d,
                            input logic exp_c, input logic exp_u,
                            input string req);
        @(negedge clk);
        rd_true = t; rd_comp = c; rd_par = p;
        @(posedge clk);
        #2;
        chk(q_data == exp_d && q_corrected == exp_c && q_uncorrectable == exp_u,
            req, {13'b0, q_corrected, q_uncorrectable, 1'b0, q_data},
            {13'b0, exp_c, exp_u, 1'b0, exp_d});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] t, c, d;
        logic p;
        // R6: reset state
        repeat (3) @(posedge clk);
        #2;
        chk(q_data == '0 && !q_corrected && !q_uncorrectable, "R6 reset",
            {15'b0, q_corrected, q_data}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            d = VEC[v];
            @(negedge clk);
            wr_data = d;
            #1;
            // R1 / R2 encoder
            chk(wr_true == d && wr_comp == ~d, "R1 images", {wr_comp, wr_true}, {~d, d});
            chk(wr_par == (^d), "R2 parity", {31'b0, wr_par}, {31'b0, ^d});
            t = wr_true; c = wr_comp; p = wr_par;
            rd_check(t, c, p, d, 1'b0, 1'b0, "R3 clean read");
            // R4: one-way flip (1 -> 0) of the charged cell at every bit
            for (int i = 0; i < W; i++) begin
                logic [W-1:0] tt, cc;
                tt = t; cc = c;
                if (d[i]) tt[i] = 1'b0; else cc[i] = 1'b0;
                rd_check(tt, cc, p, d, 1'b1, 1'b0, "R4 single flip");
            end
            // R5: two flipped pairs
            begin
                logic [W-1:0] tt, cc;
                tt = t; cc = c;
                if (d[0]) tt[0] = 1'b0; else cc[0] = 1'b0;
                if (d[W-1]) tt[W-1] = 1'b0; else cc[W-1] = 1'b0;
                rd_check(tt, cc, p, tt, 1'b0, 1'b1, "R5 double flip");
            end
            // R7: parity cell flipped alone
            rd_check(t, c, ~p, d, 1'b0, 1'b0, "R7 parity flip");
        end

        // R6: latency - output holds previous read until the next edge
        @(negedge clk);
        rd_true = 16'h00F0; rd_comp = 16'h00F0; rd_par = 1'b0;
        #2;
        chk(!q_uncorrectable, "R6 no early change", {31'b0, q_uncorrectable}, 32'h0);
        @(posedge clk);
        #2;
        chk(q_uncorrectable && q_data == 16'h00F0, "R6 one-cycle result",
            {15'b0, q_uncorrectable, q_data}, {15'b0, 1'b1, 16'h00F0});

        // R6: reset clears a FATAL verdict
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        chk(q_data == '0 && !q_uncorrectable && !q_corrected, "R6 reset clears",
            {15'b0, q_uncorrectable, q_data}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule